// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for the management register set of one Ethernet PHY. A controller issues single-cycle commands. Each command carries a 5-bit register number, a write flag and 16 bits of write data. One clock later the block answers with a done strobe and, for reads, the register contents. The model holds the control, status, advertisement, interrupt-mask and interrupt-source registers. It returns constant identification, partner-ability and expansion words. Every other register number is empty.

A link-up input enters through a synchronizer. Each transition of the synchronized level updates the link and auto-negotiation status bits and latches interrupt-source bits. Auto-negotiation is modelled as finishing at once when the control register asks for it. The interrupt-source register clears itself when it is read. A registered interrupt output is high while any latched source bit is also enabled in the mask. A write to the control register with the reset bit set returns every register to its reset value and then evaluates the current link level again.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After the reset input with the link input low, the registers read as follows: control (reg 0) 0x3000, status (reg 1) 0x7809, advertisement (reg 4) 0x01E1, mask (reg 30) 0x0000, interrupt source (reg 29) 0x0010. The last value is the link-down evaluation applied after reset.
- R2: Reg 2 reads 0x0007, reg 3 reads 0xC0D1, reg 5 reads 0x0F71 and reg 6 reads 0x0001, whatever has been written to them.
- R3: A control write with bit 15 clear stores the data ANDed with 0x7980. If data bit 12 is set, status bit 5 becomes 1 in the same cycle. A control write with bit 12 clear never clears status bit 5.
- R4: A control write with bit 15 set restores control 0x3000, advertisement 0x01E1, mask 0 and interrupt source 0. It then applies the link evaluation of R8 for the current synchronized link level. With the link up, status reads 0x782D and the interrupt source reads 0x00C0.
- R5: An advertisement write stores (data AND 0x2D7F) OR 0x0080.
- R6: A read of reg 29 returns the interrupt-source bits in the low byte. The register is zero afterwards, unless a link event lands in the same cycle.
- R7: Reg 30 keeps the low 8 bits of a write and reads them back zero-extended.
- R8: When the synchronized link level falls, status bits 2 and 5 clear and source bit 4 sets. When it rises, status bits 2 and 5 set and source bits 7 and 6 set. Each change takes effect on the (SYNC_STAGES+1)-th rising clock edge after link_i changes.
- R9: Writes to regs 1, 2, 3, 5, 6, 29 and to all unlisted numbers change no register. Reads of the unlisted numbers (e.g. 7, 17, 18, 27, 31) return 0.
- R10: irq_o is high one cycle after (source AND mask) becomes non-zero, and low one cycle after it becomes zero.
- R11: A link event in the same cycle as a read of reg 29 returns the old source bits and leaves the new event bits set.
- R12: cmd_done is high exactly one cycle after each cycle with cmd_valid high. cmd_rdata is valid while cmd_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_i | input | 1 | Asynchronous link-up indication |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 5 | Register number |
| cmd_wdata | input | 16 | Write data |
| cmd_done | output | 1 | Command completed (one cycle after cmd_valid) |
| cmd_rdata | output | 16 | Read data, valid with cmd_done |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The registers are visible at the ports only through reads and irq_o. A corrupted mask or force term therefore shows up on the next read of that register, one cycle after the command. A wrong link-update rule or a wrong synchronizer depth shows as a wrong status or source word read a fixed number of cycles after link_i moves. The same-cycle case, where a link event meets a clear-on-read, is timed to the exact edge. Losing that event bit shows on the following read of reg 29. Mask or source faults appear on irq_o two cycles after the command that changed them.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int SRC_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 5'd1;
  localparam logic [ADDR_W-1:0] A_ID_HI  = 5'd2;
  localparam logic [ADDR_W-1:0] A_ID_LO  = 5'd3;
  localparam logic [ADDR_W-1:0] A_ADV    = 5'd4;
  localparam logic [ADDR_W-1:0] A_LPA    = 5'd5;
  localparam logic [ADDR_W-1:0] A_EXP    = 5'd6;
  localparam logic [ADDR_W-1:0] A_SRC    = 5'd29;
  localparam logic [ADDR_W-1:0] A_MASK   = 5'd30;

  localparam logic [DATA_W-1:0] CTRL_RST   = 16'h3000;
  localparam logic [DATA_W-1:0] STATUS_RST = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST    = 16'h01E1;
  localparam logic [DATA_W-1:0] ID_HI_VAL  = 16'h0007;
  localparam logic [DATA_W-1:0] ID_LO_VAL  = 16'hC0D1;
  localparam logic [DATA_W-1:0] LPA_VAL    = 16'h0F71;
  localparam logic [DATA_W-1:0] EXP_VAL    = 16'h0001;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_WMASK  = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
  localparam int                CTRL_SRST_BIT = 15;
  localparam int                CTRL_ANEN_BIT = 12;
  localparam logic [DATA_W-1:0] AN_DONE    = 16'h0020;
  localparam logic [DATA_W-1:0] LINK_STAT  = 16'h0024;
  localparam logic [SRC_W-1:0]  SRC_UP     = 8'hC0;
  localparam logic [SRC_W-1:0]  SRC_DOWN   = 8'h10;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } mgmt_cmd_t;

  function automatic logic [DATA_W-1:0] status_link(input logic [DATA_W-1:0] s, input logic up);
    return up ? (s | LINK_STAT) : (s & ~LINK_STAT);
  endfunction

  function automatic logic [SRC_W-1:0] src_link(input logic [SRC_W-1:0] v, input logic up);
    return v | (up ? SRC_UP : SRC_DOWN);
  endfunction
endpackage

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic link_async,
  output logic link_level,
  output logic evt_rise,
  output logic evt_fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= link_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], link_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign link_level = chain_q[STAGES-1];
  assign evt_rise   = link_level & ~prev_q;
  assign evt_fall   = ~link_level & prev_q;
endmodule

// File: rtl/phy_reg_core.sv
module phy_reg_core
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mgmt_cmd_t         cmd,
  input  logic              link_level,
  input  logic              evt_rise,
  input  logic              evt_fall,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] adv_q,
  output logic [SRC_W-1:0]  mask_q,
  output logic [SRC_W-1:0]  src_q
);
  logic [DATA_W-1:0] ctrl_n, status_n, adv_n;
  logic [SRC_W-1:0]  mask_n, src_n;
  logic              is_wr, is_rd, soft_rst;

  assign is_wr    = cmd.valid & cmd.write;
  assign is_rd    = cmd.valid & ~cmd.write;
  assign soft_rst = is_wr && (cmd.addr == A_CTRL) && cmd.wdata[CTRL_SRST_BIT];

  always_comb begin
    ctrl_n   = ctrl_q;
    status_n = status_q;
    adv_n    = adv_q;
    mask_n   = mask_q;
    src_n    = src_q;
    if (soft_rst) begin
      ctrl_n   = CTRL_RST;
      adv_n    = ADV_RST;
      mask_n   = '0;
      status_n = status_link(STATUS_RST, link_level);
      src_n    = src_link('0, link_level);
    end else begin
      if (is_wr) begin
        case (cmd.addr)
          A_CTRL: begin
            ctrl_n = cmd.wdata & CTRL_WMASK;
            if (cmd.wdata[CTRL_ANEN_BIT]) status_n = status_n | AN_DONE;
          end
          A_ADV:  adv_n  = (cmd.wdata & ADV_WMASK) | ADV_FORCE;
          A_MASK: mask_n = cmd.wdata[SRC_W-1:0];
          default: ;
        endcase
      end else if (is_rd && cmd.addr == A_SRC) begin
        src_n = '0;
      end
      if (evt_rise) begin
        status_n = status_link(status_n, 1'b1);
        src_n    = src_link(src_n, 1'b1);
      end
      if (evt_fall) begin
        status_n = status_link(status_n, 1'b0);
        src_n    = src_link(src_n, 1'b0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      status_q <= status_link(STATUS_RST, 1'b0);
      adv_q    <= ADV_RST;
      mask_q   <= '0;
      src_q    <= src_link('0, 1'b0);
    end else begin
      ctrl_q   <= ctrl_n;
      status_q <= status_n;
      adv_q    <= adv_n;
      mask_q   <= mask_n;
      src_q    <= src_n;
    end
  end

  // R3
  ctrl_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_WMASK) == '0);

  // R5
  adv_force_chk: assert property (@(posedge clk) disable iff (rst)
    adv_q[7] && ((adv_q & ~(ADV_WMASK | ADV_FORCE)) == '0));

  // R6
  src_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rd && cmd.addr == A_SRC && !evt_rise && !evt_fall) |=> (src_q == '0));

  // R8
  link_up_chk: assert property (@(posedge clk) disable iff (rst)
    evt_rise |=> (src_q[7] && src_q[6] && status_q[2] && status_q[5]));

  // R8
  link_down_chk: assert property (@(posedge clk) disable iff (rst)
    evt_fall |=> (src_q[4] && !status_q[2] && !status_q[5]));
endmodule

// File: rtl/phy_read_port.sv
module phy_read_port
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] status_q,
  input  logic [DATA_W-1:0] adv_q,
  input  logic [SRC_W-1:0]  mask_q,
  input  logic [SRC_W-1:0]  src_q,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - SRC_W;
  logic [DATA_W-1:0] mux;

  always_comb begin
    case (addr)
      A_CTRL:   mux = ctrl_q;
      A_STATUS: mux = status_q;
      A_ID_HI:  mux = ID_HI_VAL;
      A_ID_LO:  mux = ID_LO_VAL;
      A_ADV:    mux = adv_q;
      A_LPA:    mux = LPA_VAL;
      A_EXP:    mux = EXP_VAL;
      A_SRC:    mux = {{PAD_W{1'b0}}, src_q};
      A_MASK:   mux = {{PAD_W{1'b0}}, mask_q};
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done  <= valid;
      rdata <= (valid && !write) ? mux : '0;
    end
  end

  // R12
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !done);
endmodule

// File: rtl/phy_irq_gen.sv
module phy_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(src & mask);
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_i,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_done,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              irq_o
);
  mgmt_cmd_t         cmd;
  logic              link_level, evt_rise, evt_fall;
  logic [DATA_W-1:0] ctrl_q, status_q, adv_q;
  logic [SRC_W-1:0]  mask_q, src_q;

  assign cmd = '{valid: cmd_valid, write: cmd_write, addr: cmd_addr, wdata: cmd_wdata};

  phy_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .link_async(link_i),
    .link_level(link_level), .evt_rise(evt_rise), .evt_fall(evt_fall)
  );

  phy_reg_core u_core (
    .clk(clk), .rst(rst), .cmd(cmd), .link_level(link_level),
    .evt_rise(evt_rise), .evt_fall(evt_fall),
    .ctrl_q(ctrl_q), .status_q(status_q), .adv_q(adv_q),
    .mask_q(mask_q), .src_q(src_q)
  );

  phy_read_port u_rd (
    .clk(clk), .rst(rst), .valid(cmd_valid), .write(cmd_write), .addr(cmd_addr),
    .ctrl_q(ctrl_q), .status_q(status_q), .adv_q(adv_q),
    .mask_q(mask_q), .src_q(src_q), .done(cmd_done), .rdata(cmd_rdata)
  );

  phy_irq_gen #(.W(SRC_W)) u_irq (
    .clk(clk), .rst(rst), .src(src_q), .mask(mask_q), .irq(irq_o)
  );

  // R10
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_o);
endmodule

// File: tb/phy_mgmt_regs_tb.sv
`timescale 1ns/1ps
module phy_mgmt_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_i = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [4:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_done;
  logic [15:0] cmd_rdata;
  logic        irq_o;
  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  phy_mgmt_regs u_dut (
    .clk(clk), .rst(rst), .link_i(link_i), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic op(input logic wr, input logic [4:0] a, input logic [15:0] d,
                    output logic [15:0] q);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
    chk("R12 done", {15'd0, cmd_done}, 16'd1);
    q = cmd_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] q;
    op(1'b1, a, d, q);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] q;
    op(1'b0, a, 16'h0, q);
    chk(req, q, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 idle", {15'd0, cmd_done}, 16'd0);
    chk("R10 irq reset", {15'd0, irq_o}, 16'd0);
    rd_chk("R1 ctrl", 5'd0, 16'h3000);
    rd_chk("R1 status", 5'd1, 16'h7809);
    rd_chk("R1 adv", 5'd4, 16'h01E1);
    rd_chk("R1 mask", 5'd30, 16'h0000);
    rd_chk("R1 src", 5'd29, 16'h0010);
    rd_chk("R6 src cleared", 5'd29, 16'h0000);
    wait_cyc(1);
    chk("R12 idle after op", {15'd0, cmd_done}, 16'd0);
  endtask

  task automatic t_ident;
    wr(5'd2, 16'h1234); wr(5'd3, 16'h5678); wr(5'd5, 16'h0); wr(5'd6, 16'hFFFF);
    rd_chk("R2 id hi", 5'd2, 16'h0007);
    rd_chk("R2 id lo", 5'd3, 16'hC0D1);
    rd_chk("R2 partner", 5'd5, 16'h0F71);
    rd_chk("R2 expansion", 5'd6, 16'h0001);
  endtask

  task automatic t_ctrl;
    wr(5'd0, 16'h1000);
    rd_chk("R3 ctrl an", 5'd0, 16'h1000);
    rd_chk("R3 status an done", 5'd1, 16'h7829);
    wr(5'd0, 16'h0E7F);
    rd_chk("R3 ctrl mask", 5'd0, 16'h0800);
    rd_chk("R3 status kept", 5'd1, 16'h7829);
    wr(5'd0, 16'h7FFF);
    rd_chk("R3 ctrl all", 5'd0, 16'h7980);
  endtask

  task automatic t_adv;
    wr(5'd4, 16'hFFFF); rd_chk("R5 adv ones", 5'd4, 16'h2DFF);
    wr(5'd4, 16'h0000); rd_chk("R5 adv zero", 5'd4, 16'h0080);
    wr(5'd4, 16'h1234); rd_chk("R5 adv mix", 5'd4, 16'h00B4);
  endtask

  task automatic t_link_up;
    link_i = 1'b1;
    wait_cyc(5);
    rd_chk("R8 status up", 5'd1, 16'h782D);
    rd_chk("R8 src up", 5'd29, 16'h00C0);
    rd_chk("R6 src clear up", 5'd29, 16'h0000);
  endtask

  task automatic t_mask_irq;
    wr(5'd30, 16'hABCD);
    rd_chk("R7 mask low byte", 5'd30, 16'h00CD);
    link_i = 1'b0;
    wait_cyc(5);
    chk("R10 irq masked", {15'd0, irq_o}, 16'd0);
    wr(5'd30, 16'h0010);
    wait_cyc(1);
    chk("R10 irq on", {15'd0, irq_o}, 16'd1);
    rd_chk("R8 src down", 5'd29, 16'h0010);
    wait_cyc(1);
    chk("R10 irq off", {15'd0, irq_o}, 16'd0);
    rd_chk("R8 status down", 5'd1, 16'h7809);
  endtask

  task automatic t_unlisted;
    // state now: ctrl 7980, status 7809, adv 00B4, mask 0010, src 0
    wr(5'd1, 16'hFFFF); wr(5'd29, 16'hFFFF); wr(5'd17, 16'hFFFF);
    wr(5'd18, 16'hFFFF); wr(5'd27, 16'hFFFF); wr(5'd31, 16'hFFFF);
    wr(5'd7, 16'hFFFF); wr(5'd15, 16'hFFFF);
    rd_chk("R9 ctrl kept", 5'd0, 16'h7980);
    rd_chk("R9 status kept", 5'd1, 16'h7809);
    rd_chk("R9 adv kept", 5'd4, 16'h00B4);
    rd_chk("R9 mask kept", 5'd30, 16'h0010);
    rd_chk("R9 src kept", 5'd29, 16'h0000);
    rd_chk("R9 reg17", 5'd17, 16'h0000);
    rd_chk("R9 reg18", 5'd18, 16'h0000);
    rd_chk("R9 reg27", 5'd27, 16'h0000);
    rd_chk("R9 reg31", 5'd31, 16'h0000);
    rd_chk("R9 reg7", 5'd7, 16'h0000);
  endtask

  task automatic t_soft_reset;
    link_i = 1'b1;
    wait_cyc(5);
    rd_chk("R8 src up again", 5'd29, 16'h00C0);
    wr(5'd30, 16'h00FF);
    wr(5'd0, 16'h8000);
    rd_chk("R4 ctrl", 5'd0, 16'h3000);
    rd_chk("R4 adv", 5'd4, 16'h01E1);
    rd_chk("R4 mask", 5'd30, 16'h0000);
    rd_chk("R4 status", 5'd1, 16'h782D);
    rd_chk("R4 src", 5'd29, 16'h00C0);
  endtask

  task automatic t_race;
    logic [15:0] q;
    link_i = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    op(1'b0, 5'd29, 16'h0, q);
    chk("R11 old value returned", q, 16'h0000);
    rd_chk("R11 event kept", 5'd29, 16'h0010);
    rd_chk("R8 status after race", 5'd1, 16'h7809);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_ctrl();
    t_adv();
    t_link_up();
    t_mask_irq();
    t_unlisted();
    t_soft_reset();
    t_race();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    finish_run();
  end
endmodule